// File: doc/BRIEF.md
# Immediate Combined-Operation ALU

This block evaluates a family of undocumented immediate-operand instructions of an 8-bit accumulator processor. Each instruction merges two ordinary steps into one. Every transaction carries an opcode byte, an immediate byte, the current accumulator and index register values, and the current status flags. The block returns the new accumulator, the new index register and the new flags.

Transactions enter on a valid/ready input channel. Results leave on a valid/ready output channel one cycle after they are accepted. Back-pressure follows two rules. A transaction is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A result stays on the output, unchanged, until the consumer takes it by raising `out_ready`.

Flags travel as a 4-bit vector ordered {N, V, Z, C}: bit 3 is N, bit 2 is V, bit 1 is Z and bit 0 is C. A flag that an operation does not name keeps its incoming value.

Top module: `imm_combo_alu`

## Requirements
- R1: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. A transaction accepted on one clock edge appears on the outputs with `out_valid` high after that same edge.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid` and every output data bit hold their values.
- R3: Opcodes 0x0B and 0x2B set A to (A AND imm). N and C both take bit 7 of that result, and Z is set when the result is zero.
- R4: Opcode 0x4B sets A to (A AND imm) shifted right by one place. C takes the bit shifted out, N is cleared and Z is set when the new A is zero.
- R5: Opcode 0x6B sets A to (A AND imm) rotated right, with the incoming C entering bit 7. N takes the new bit 7 and Z is set when the new A is zero.
- R6: For opcode 0x6B, C becomes bit 6 of the new A and V becomes bit 6 XOR bit 5 of the new A. Bit 0 of the AND result is discarded.
- R7: Opcode 0xCB sets X to ((A AND X) − imm) modulo 256, ignoring the incoming C. A and V are unchanged.
- R8: For opcode 0xCB, C is set when (A AND X) ≥ imm (unsigned), N takes bit 7 of the new X and Z is set when the new X is zero.
- R9: Opcode 0xEB sets A to A − imm − (1 − C) in binary. C is set when no borrow occurs, V flags a signed overflow, and N and Z follow the new A.
- R10: Opcode 0xAB loads imm into both A and X. N and Z follow imm.
- R11: Opcode 0x8B leaves A, X and the flags unchanged, with `unsupported` low.
- R12: Any opcode outside the set above leaves A, X and the flags unchanged, with `unsupported` high. Every supported opcode gives `unsupported` low.
- R13: After reset, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input transaction offered |
| in_ready | output | 1 | Input transaction can be taken |
| opcode | input | 8 | Instruction opcode |
| imm | input | 8 | Immediate operand |
| a_in | input | 8 | Current accumulator |
| x_in | input | 8 | Current index register |
| flags_in | input | 4 | Current flags {N,V,Z,C} |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| a_out | output | 8 | New accumulator |
| x_out | output | 8 | New index register |
| flags_out | output | 4 | New flags {N,V,Z,C} |
| unsupported | output | 1 | Opcode not in the handled set |

## Verification
Directed patterns probe the edges of each operation.

- AND results of zero and 0x80 separate the zero and sign paths.
- A rotate with the incoming carry set, and a rotate with bits 6 and 5 of the new A differing, tell the special carry and overflow rules apart from an ordinary rotate.
- Subtract-into-X cases with (A AND X) equal to, below and above imm tell the compare-style carry apart from a borrow-style one, and show that the incoming carry is ignored.
- Subtract-with-borrow cases cover signed overflow in both directions and both values of the incoming carry.

A pseudo-random sweep over all opcodes, including unsupported ones, runs with a toggling `out_ready`. It checks that results keep their order and stay stable under stall.

// File: rtl/icalu_pkg.sv
package icalu_pkg;
  localparam int DW     = 8;
  localparam int OPW    = 8;
  localparam int FLAGW  = 4;
  localparam int F_N    = 3;
  localparam int F_V    = 2;
  localparam int F_Z    = 1;
  localparam int F_C    = 0;

  typedef enum logic [2:0] {
    K_ANDC, K_ANDSHR, K_ANDROR, K_MASKSUB, K_SUBB, K_LOADAX, K_KEEP, K_BAD
  } op_kind_e;

  typedef struct packed {
    logic [DW-1:0]    acc;
    logic [DW-1:0]    idx;
    logic [FLAGW-1:0] flg;
    logic             bad;
  } alu_res_t;

  localparam int RESW = $bits(alu_res_t);
endpackage

// File: rtl/icalu_decode.sv
module icalu_decode
  import icalu_pkg::*;
(
  input  logic [OPW-1:0] opcode,
  output op_kind_e       kind
);
  always_comb begin
    unique case (opcode)
      8'h0B, 8'h2B: kind = K_ANDC;
      8'h4B:        kind = K_ANDSHR;
      8'h6B:        kind = K_ANDROR;
      8'hCB:        kind = K_MASKSUB;
      8'hEB:        kind = K_SUBB;
      8'hAB:        kind = K_LOADAX;
      8'h8B:        kind = K_KEEP;
      default:      kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/icalu_core.sv
module icalu_core
  import icalu_pkg::*;
(
  input  op_kind_e         kind,
  input  logic [DW-1:0]    acc,
  input  logic [DW-1:0]    idx,
  input  logic [DW-1:0]    imm,
  input  logic [FLAGW-1:0] flg,
  output alu_res_t         res
);
  localparam int MSB = DW - 1;

  logic [DW-1:0] masked;
  logic [DW-1:0] shr_val;
  logic [DW-1:0] ror_val;
  logic [DW-1:0] ax_val;
  logic [DW:0]   mask_diff;
  logic [DW:0]   sub_diff;

  always_comb begin
    masked    = acc & imm;
    shr_val   = masked >> 1;
    ror_val   = {flg[F_C], masked[MSB:1]};
    ax_val    = acc & idx;
    mask_diff = {1'b0, ax_val} - {1'b0, imm};
    sub_diff  = {1'b0, acc} - {1'b0, imm} - {{DW{1'b0}}, ~flg[F_C]};

    res.acc = acc;
    res.idx = idx;
    res.flg = flg;
    res.bad = 1'b0;

    unique case (kind)
      K_ANDC: begin
        res.acc      = masked;
        res.flg[F_N] = masked[MSB];
        res.flg[F_Z] = (masked == '0);
        res.flg[F_C] = masked[MSB];
      end
      K_ANDSHR: begin
        res.acc      = shr_val;
        res.flg[F_N] = 1'b0;
        res.flg[F_Z] = (shr_val == '0);
        res.flg[F_C] = masked[0];
      end
      K_ANDROR: begin
        res.acc      = ror_val;
        res.flg[F_N] = ror_val[MSB];
        res.flg[F_Z] = (ror_val == '0);
        res.flg[F_C] = ror_val[MSB-1];
        res.flg[F_V] = ror_val[MSB-1] ^ ror_val[MSB-2];
      end
      K_MASKSUB: begin
        res.idx      = mask_diff[DW-1:0];
        res.flg[F_N] = mask_diff[MSB];
        res.flg[F_Z] = (mask_diff[DW-1:0] == '0);
        res.flg[F_C] = ~mask_diff[DW];
      end
      K_SUBB: begin
        res.acc      = sub_diff[DW-1:0];
        res.flg[F_N] = sub_diff[MSB];
        res.flg[F_Z] = (sub_diff[DW-1:0] == '0);
        res.flg[F_C] = ~sub_diff[DW];
        res.flg[F_V] = (acc[MSB] ^ imm[MSB]) & (acc[MSB] ^ sub_diff[MSB]);
      end
      K_LOADAX: begin
        res.acc      = imm;
        res.idx      = imm;
        res.flg[F_N] = imm[MSB];
        res.flg[F_Z] = (imm == '0);
      end
      K_KEEP: begin
        res.bad = 1'b0;
      end
      default: begin
        res.bad = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/icalu_stage.sv
module icalu_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  logic         held_v;
  logic [W-1:0] held_d;

  assign s_ready = ~held_v | m_ready;
  assign m_valid = held_v;
  assign m_data  = held_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_v <= 1'b0;
    end else if (s_valid && s_ready) begin
      held_v <= 1'b1;
    end else if (m_ready) begin
      held_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (s_valid && s_ready) held_d <= s_data;
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data))) else $error("stall hold"); // R2
  AST_RESET_EMPTY: assert property (@(posedge clk)
    !rst_n |=> !m_valid) else $error("reset valid"); // R13
endmodule

// File: rtl/imm_combo_alu.sv
module imm_combo_alu
  import icalu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OPW-1:0]   opcode,
  input  logic [DW-1:0]    imm,
  input  logic [DW-1:0]    a_in,
  input  logic [DW-1:0]    x_in,
  input  logic [FLAGW-1:0] flags_in,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    a_out,
  output logic [DW-1:0]    x_out,
  output logic [FLAGW-1:0] flags_out,
  output logic             unsupported
);
  op_kind_e  kind;
  alu_res_t  next_res;
  alu_res_t  cur_res;
  logic [RESW-1:0] cur_bits;

  icalu_decode u_dec (.opcode(opcode), .kind(kind));

  icalu_core u_core (
    .kind(kind), .acc(a_in), .idx(x_in), .imm(imm), .flg(flags_in), .res(next_res)
  );

  icalu_stage #(.W(RESW)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .s_valid(in_valid), .s_ready(in_ready), .s_data(next_res),
    .m_valid(out_valid), .m_ready(out_ready), .m_data(cur_bits)
  );

  assign cur_res     = alu_res_t'(cur_bits);
  assign a_out       = cur_res.acc;
  assign x_out       = cur_res.idx;
  assign flags_out   = cur_res.flg;
  assign unsupported = cur_res.bad;

  logic take;
  assign take = in_valid & in_ready;

  AST_TAKE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid) else $error("result missing"); // R1
  AST_ANDC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (opcode == 8'h0B || opcode == 8'h2B)) |=> (flags_out[F_C] == a_out[DW-1]))
    else $error("andc carry"); // R3
  AST_SHR_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (take && opcode == 8'h4B) |=> !flags_out[F_N]) else $error("shr N"); // R4
  AST_ROR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && opcode == 8'h6B) |=>
      (flags_out[F_V] == (a_out[DW-2] ^ a_out[DW-3]) && flags_out[F_C] == a_out[DW-2]))
    else $error("ror flags"); // R6
  AST_MASKSUB_KEEPA: assert property (@(posedge clk) disable iff (!rst_n)
    (take && opcode == 8'hCB) |=> (a_out == $past(a_in) && flags_out[F_V] == $past(flags_in[F_V])))
    else $error("masksub A"); // R7
  AST_LOAD_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (take && opcode == 8'hAB) |=> (a_out == x_out && a_out == $past(imm)))
    else $error("load both"); // R10
  AST_BAD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && unsupported == 1'b0 && next_res.bad) |=>
      (unsupported && a_out == $past(a_in) && x_out == $past(x_in) && flags_out == $past(flags_in)))
    else $error("unsupported keep"); // R12
endmodule

// File: tb/imm_combo_alu_test.sv
module imm_combo_alu_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] opcode = '0, imm = '0, a_in = '0, x_in = '0;
  logic [3:0] flags_in = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [7:0] a_out, x_out;
  logic [3:0] flags_out;
  logic unsupported;

  always #(CLK_PERIOD/2) clk = ~clk;

  imm_combo_alu uut (.*);

  typedef struct {
    logic [7:0] a;
    logic [7:0] x;
    logic [3:0] f;
    logic       bad;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  bit rand_ready = 0;
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic exp_t model(input logic [7:0] op, input logic [7:0] im,
                                 input logic [7:0] a, input logic [7:0] x,
                                 input logic [3:0] f);
    exp_t e;
    logic [7:0] t;
    int d;
    e.a = a; e.x = x; e.f = f; e.bad = 0; e.tag = "R12";
    t = a & im;
    case (op)
      8'h0B, 8'h2B: begin e.a = t; e.f[3] = t[7]; e.f[1] = (t == 0); e.f[0] = t[7]; e.tag = "R3"; end
      8'h4B: begin e.a = t / 2; e.f[3] = 0; e.f[1] = (e.a == 0); e.f[0] = t[0]; e.tag = "R4"; end
      8'h6B: begin
        e.a = (t / 2) + (f[0] ? 8'h80 : 8'h00);
        e.f[3] = e.a[7]; e.f[1] = (e.a == 0); e.f[0] = e.a[6]; e.f[2] = e.a[6] ^ e.a[5];
        e.tag = "R5/R6";
      end
      8'hCB: begin
        d = int'(a & x) - int'(im);
        e.x = 8'(d); e.f[3] = e.x[7]; e.f[1] = (e.x == 0); e.f[0] = (d >= 0); e.tag = "R7/R8";
      end
      8'hEB: begin
        d = int'(a) - int'(im) - (f[0] ? 0 : 1);
        e.a = 8'(d); e.f[0] = (d >= 0);
        e.f[2] = ($signed(a) - $signed(im) - (f[0] ? 0 : 1) > 127) ||
                 ($signed(a) - $signed(im) - (f[0] ? 0 : 1) < -128);
        e.f[3] = e.a[7]; e.f[1] = (e.a == 0); e.tag = "R9";
      end
      8'hAB: begin e.a = im; e.x = im; e.f[3] = im[7]; e.f[1] = (im == 0); e.tag = "R10"; end
      8'h8B: e.tag = "R11";
      default: e.bad = 1;
    endcase
    return e;
  endfunction

  task automatic send(input logic [7:0] op, input logic [7:0] im, input logic [7:0] a,
                      input logic [7:0] x, input logic [3:0] f);
    in_valid = 1; opcode = op; imm = im; a_in = a; x_in = x; flags_in = f;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    sb.push_back(model(op, im, a, x, f));
    @(negedge clk);
    in_valid = 0;
  endtask

  // monitor / scoreboard
  initial begin
    bit stall_prev = 0;
    logic [7:0] pa, px; logic [3:0] pf; logic pb;
    forever begin
      @(negedge clk);
      if (rand_ready) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = lfsr[0];
      end else out_ready = 1;
      #2;
      if (rst_n) begin
        if (stall_prev) begin
          checks++;
          if (!out_valid || a_out != pa || x_out != px || flags_out != pf || unsupported != pb) begin
            errors++;
            $display("FAIL R2 stall: got v=%0b %h %h %h %b exp held %h %h %h %b",
                     out_valid, a_out, x_out, flags_out, unsupported, pa, px, pf, pb);
          end
        end
        checks++;
        if (in_ready != (!out_valid || out_ready)) begin
          errors++;
          $display("FAIL R1 in_ready=%0b exp %0b", in_ready, !out_valid || out_ready);
        end
        if (out_valid && out_ready) begin
          exp_t e;
          checks++;
          if (sb.size() == 0) begin
            errors++;
            $display("FAIL R1 unexpected output got %h exp none", a_out);
          end else begin
            e = sb.pop_front();
            if (a_out != e.a || x_out != e.x || flags_out != e.f || unsupported != e.bad) begin
              errors++;
              $display("FAIL %s got A=%h X=%h F=%b U=%b exp A=%h X=%h F=%b U=%b",
                       e.tag, a_out, x_out, flags_out, unsupported, e.a, e.x, e.f, e.bad);
            end
          end
        end
        stall_prev = out_valid && !out_ready;
        pa = a_out; px = x_out; pf = flags_out; pb = unsupported;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #3;
    checks++;
    if (out_valid !== 1'b0) begin errors++; $display("FAIL R13 out_valid=%b exp 0", out_valid); end
    @(negedge clk);
    // R3 zero / sign
    send(8'h0B, 8'h0F, 8'hF0, 8'h11, 4'b0101);
    send(8'h2B, 8'hC0, 8'h80, 8'h00, 4'b0000);
    // R4
    send(8'h4B, 8'h01, 8'h01, 8'h00, 4'b1000);
    send(8'h4B, 8'hFE, 8'hFF, 8'h00, 4'b0001);
    // R5 R6
    send(8'h6B, 8'hFF, 8'hFF, 8'h00, 4'b0001);
    send(8'h6B, 8'h40, 8'h40, 8'h00, 4'b0000);
    send(8'h6B, 8'h60, 8'h7F, 8'h00, 4'b0100);
    send(8'h6B, 8'h01, 8'h01, 8'h00, 4'b0000);
    // R7 R8 equal, below, above, carry ignored
    send(8'hCB, 8'h0F, 8'hFF, 8'h0F, 4'b0000);
    send(8'hCB, 8'h10, 8'hFF, 8'h0F, 4'b0111);
    send(8'hCB, 8'h05, 8'h3C, 8'hF7, 4'b0000);
    // R9
    send(8'hEB, 8'hB0, 8'h50, 8'h00, 4'b0001);
    send(8'hEB, 8'h01, 8'h80, 8'h00, 4'b0001);
    send(8'hEB, 8'h00, 8'h00, 8'h00, 4'b0000);
    send(8'hEB, 8'h20, 8'h30, 8'h00, 4'b0000);
    // R10 R11 R12
    send(8'hAB, 8'h00, 8'h55, 8'h66, 4'b1000);
    send(8'hAB, 8'h9A, 8'h00, 8'h00, 4'b0010);
    send(8'h8B, 8'h12, 8'h34, 8'h56, 4'b1011);
    send(8'h00, 8'h12, 8'h34, 8'h56, 4'b0110);
    send(8'hEA, 8'hFF, 8'h01, 8'h02, 4'b1001);
    // sweep with back-pressure
    rand_ready = 1;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      logic [7:0] op;
      r = $urandom;
      case (r[3:0])
        0: op = 8'h0B; 1: op = 8'h2B; 2: op = 8'h4B; 3, 4: op = 8'h6B;
        5, 6: op = 8'hCB; 7, 8: op = 8'hEB; 9: op = 8'hAB; 10: op = 8'h8B;
        default: op = r[31:24];
      endcase
      send(op, r[7:0], r[15:8], r[23:16], r[27:24]);
      if (r[5]) @(negedge clk);
    end
    rand_ready = 0;
    repeat (10) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin errors++; $display("FAIL R1 pending=%0d exp 0", sb.size()); end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule